// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block resolves the operand of an already decoded instruction. It receives a mode code, an address field A, a register selector and an indirection depth, together with a start pulse. Each mode needs a different number of memory reads, from none to four, and the block issues those reads one after another. It then returns the operand with a one-cycle done pulse. It reads a flattened register file and the current program counter directly from its inputs. Memory is reached through a request/valid read port, and the memory may take one or more cycles to answer each request.

A pointer fetched from memory can become the address of the next read. This lets the block follow chains of pointers up to three levels deep. It also supports the two ways of combining a register with one level of indirection: the register can be added before the pointer fetch, or added to the fetched pointer afterwards. All address sums wrap modulo 2^W, and no overflow is flagged.

Top module: `oau_top`

## Requirements
- R1: Mode code 0 (immediate) returns A as the operand and issues no memory read.
- R2: Mode code 1 (direct) issues one read at address A and returns the word read.
- R3: Mode code 2 (indirect) first reads the word at A. It then follows pointers for d levels and returns the last word read, for a total of d+1 reads. The depth field gives d in the range 1 to 3, and a depth field of 0 is treated as 1.
- R4: Mode code 3 (register) returns the content of the selected register (slot k at bits k*W+W-1..k*W of the register bus) and issues no memory read.
- R5: Mode code 4 (register indirect) issues one read at the address held in the selected register and returns the word read.
- R6: Mode code 5 (displacement) issues one read at (A + selected register) mod 2^W and returns the word read.
- R7: Mode code 6 (relative) issues one read at (A + PC) mod 2^W and returns the word read.
- R8: Mode code 7 (preindexed indirect) reads a pointer at (A + selected register) mod 2^W, then reads the operand at that pointer. This is two reads in total.
- R9: Mode code 8 (postindexed indirect) reads a pointer at A, then reads the operand at (pointer + selected register) mod 2^W. This is two reads in total.
- R10: Each read is a single-cycle request, and no new request is issued until the previous one has returned valid data. Done is a one-cycle pulse, and the operand output holds its value until the next done.
- R11: Busy rises in the cycle after a start is accepted while idle and stays high up to and including the done cycle. A start that arrives while busy is ignored.
- R12: Mode codes 9 to 15 behave as immediate: the operand is A and no read is issued.
- R13: The register contents and the PC are sampled in the start cycle. Later changes to them do not affect the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving an operand |
| mode | input | 4 | Addressing mode code |
| addr_a | input | W | Address field A |
| reg_sel | input | log2(NREG) | Register selector |
| depth | input | 2 | Indirection depth for mode 2 |
| regs_flat | input | NREG*W | Register file contents, slot k at bits k*W+W-1..k*W |
| pc | input | W | Current program counter |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | W | Read address, valid with mem_req |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operand ready pulse |
| operand | output | W | Resolved operand |

## Verification
On every cycle, the assertions check the protocol and the cost side of each mode. They confirm that requests are single-cycle and never overlap an outstanding read, and that done is a pulse. They also confirm that busy holds from an accepted start to done, that the immediate, reserved and register modes never touch memory, and that the number of reads matches the mode and depth. Whether the right addresses were read and whether the operand value is correct can only be shown by the bench. The bench sweeps every mode code over many A values, register selections, depths and memory latencies. It compares each result against arithmetic on a memory whose content is a known function of the address. It also changes the register file and PC during an operation and sends stray starts while the block is busy.

// File: rtl/oau_pkg.sv
// Package: shared mode codes and sequencer states for the operand fetch unit.
// Assumes mode codes are 4 bits wide; codes above 8 are reserved.
package oau_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        M_IMM  = 4'd0,
        M_DIR  = 4'd1,
        M_IND  = 4'd2,
        M_REG  = 4'd3,
        M_RIND = 4'd4,
        M_DISP = 4'd5,
        M_REL  = 4'd6,
        M_PRE  = 4'd7,
        M_POST = 4'd8
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2,
        S_FIN  = 2'd3
    } state_e;
endpackage

// File: rtl/oau_reg_read.sv
// Module: selects one register from a flattened register-file bus.
// Assumes NREG is a power of two; slot k sits at bits k*W+W-1..k*W.
module oau_reg_read #(
    parameter int W    = 8,
    parameter int NREG = 4,
    localparam int RSW = $clog2(NREG)
) (
    input  logic [NREG*W-1:0] regs_flat,
    input  logic [RSW-1:0]    sel,
    output logic [W-1:0]      rval
);
    logic [W-1:0] slots [NREG];

    // Unpack the flat bus into one slot per register.
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        assign slots[g] = regs_flat[g*W +: W];
    end

    // Pick the selected register.
    assign rval = slots[sel];
endmodule

// File: rtl/oau_first_addr.sv
// Module: decodes the mode and forms the first read address, the read count,
// the post-add flag and the no-read result. Purely combinational; the
// caller samples its outputs in the start cycle.
module oau_first_addr
    import oau_pkg::*;
#(
    parameter int W       = 8,
    parameter int DEPTH_W = 2,
    localparam int CNT_W  = DEPTH_W + 1
) (
    input  logic [MODE_W-1:0]  mode,
    input  logic [W-1:0]       addr_a,
    input  logic [W-1:0]       rval,
    input  logic [W-1:0]       pc,
    input  logic [DEPTH_W-1:0] depth,
    output logic [W-1:0]       first_addr,
    output logic [CNT_W-1:0]   nreads,
    output logic               post_add,
    output logic [W-1:0]       direct_val
);
    logic [CNT_W-1:0] levels;

    // A depth field of zero still means one level of indirection.
    always_comb begin
        levels = CNT_W'(depth);
        if (depth == '0) levels = CNT_W'(1);
    end

    // Mode decode: first address, number of reads, post-add, no-read value.
    always_comb begin
        first_addr = addr_a;
        nreads     = '0;
        post_add   = 1'b0;
        direct_val = addr_a;
        case (mode)
            M_DIR:  nreads = CNT_W'(1);
            M_IND:  nreads = levels + CNT_W'(1);
            M_REG:  direct_val = rval;
            M_RIND: begin first_addr = rval;          nreads = CNT_W'(1); end
            M_DISP: begin first_addr = addr_a + rval; nreads = CNT_W'(1); end
            M_REL:  begin first_addr = addr_a + pc;   nreads = CNT_W'(1); end
            M_PRE:  begin first_addr = addr_a + rval; nreads = CNT_W'(2); end
            M_POST: begin nreads = CNT_W'(2); post_add = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/oau_seq.sv
// Module: sequencer that issues the reads one at a time and chains each
// returned word into the next address. Assumes memory answers each request
// with mem_valid no earlier than the cycle after the request.
module oau_seq
    import oau_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     first_addr,
    input  logic [CNT_W-1:0] nreads,
    input  logic             post_add,
    input  logic [W-1:0]     direct_val,
    input  logic [W-1:0]     rval,
    output logic             mem_req,
    output logic [W-1:0]     mem_addr,
    input  logic             mem_valid,
    input  logic [W-1:0]     mem_rdata,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     operand
);
    state_e           state;
    logic [W-1:0]     addr_q;
    logic [W-1:0]     rval_q;
    logic [W-1:0]     res_q;
    logic [CNT_W-1:0] left_q;
    logic             post_q;

    // State, chained address and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            addr_q <= '0;
            rval_q <= '0;
            res_q  <= '0;
            left_q <= '0;
            post_q <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    addr_q <= first_addr;
                    rval_q <= rval;
                    left_q <= nreads;
                    post_q <= post_add;
                    if (nreads == '0) begin
                        res_q <= direct_val;
                        state <= S_FIN;
                    end else begin
                        state <= S_REQ;
                    end
                end
                S_REQ: state <= S_WAIT;
                S_WAIT: if (mem_valid) begin
                    if (left_q == CNT_W'(1)) begin
                        res_q <= mem_rdata;
                        state <= S_FIN;
                    end else begin
                        addr_q <= mem_rdata + (post_q ? rval_q : '0);
                        left_q <= left_q - CNT_W'(1);
                        state  <= S_REQ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output decode from the current state.
    assign mem_req  = (state == S_REQ);
    assign mem_addr = addr_q;
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_FIN);
    assign operand  = res_q;
endmodule

// File: rtl/oau_top.sv
// Module: operand fetch unit top. Joins register select, mode decode and
// the read sequencer. Assumes a single-word memory read port.
module oau_top
    import oau_pkg::*;
#(
    parameter int W       = 8,
    parameter int NREG    = 4,
    parameter int DEPTH_W = 2,
    localparam int RSW    = $clog2(NREG),
    localparam int CNT_W  = DEPTH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MODE_W-1:0]  mode,
    input  logic [W-1:0]       addr_a,
    input  logic [RSW-1:0]     reg_sel,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [NREG*W-1:0]  regs_flat,
    input  logic [W-1:0]       pc,
    output logic               mem_req,
    output logic [W-1:0]       mem_addr,
    input  logic               mem_valid,
    input  logic [W-1:0]       mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [W-1:0]       operand
);
    logic [W-1:0]     rval;
    logic [W-1:0]     first_addr;
    logic [W-1:0]     direct_val;
    logic [CNT_W-1:0] nreads;
    logic             post_add;
    logic             start_ok;

    // Only an idle unit accepts a start.
    assign start_ok = start && !busy;

    oau_reg_read #(.W(W), .NREG(NREG)) u_rr (
        .regs_flat(regs_flat), .sel(reg_sel), .rval(rval)
    );

    oau_first_addr #(.W(W), .DEPTH_W(DEPTH_W)) u_fa (
        .mode(mode), .addr_a(addr_a), .rval(rval), .pc(pc), .depth(depth),
        .first_addr(first_addr), .nreads(nreads), .post_add(post_add),
        .direct_val(direct_val)
    );

    oau_seq #(.W(W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_ok),
        .first_addr(first_addr), .nreads(nreads), .post_add(post_add),
        .direct_val(direct_val), .rval(rval),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .operand(operand)
    );
endmodule

// File: rtl/oau_checker.sv
// Module: protocol and read-count checker for oau_top, attached by bind.
// Tracks the outstanding read and counts reads per accepted operation.
module oau_checker #(
    parameter int DEPTH_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [3:0]         mode,
    input logic [DEPTH_W-1:0] depth,
    input logic               mem_req,
    input logic               mem_valid,
    input logic               busy,
    input logic               done
);
    logic       pend;
    logic [3:0] mode_q;
    logic [3:0] exp_q;
    logic [3:0] cnt;

    // Track one outstanding read, counted reads, and the expected count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            mode_q <= '0;
            exp_q  <= '0;
            cnt    <= '0;
        end else begin
            if (mem_req) pend <= 1'b1;
            else if (mem_valid) pend <= 1'b0;
            if (start && !busy) begin
                mode_q <= mode;
                cnt    <= '0;
                case (mode)
                    4'd1, 4'd4, 4'd5, 4'd6: exp_q <= 4'd1;
                    4'd7, 4'd8:             exp_q <= 4'd2;
                    4'd2: exp_q <= (depth == '0) ? 4'd2 : 4'(depth) + 4'd1;
                    default:                exp_q <= 4'd0;
                endcase
            end else if (mem_req) begin
                cnt <= cnt + 4'd1;
            end
        end
    end

    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R10
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pend); // R10
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R11
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R11
    AST_IMM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mode_q == 4'd0 || mode_q > 4'd8)) |-> !mem_req); // R1
    AST_REG_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == 4'd3) |-> !mem_req); // R4
    AST_READ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == exp_q)); // R3
endmodule

bind oau_top oau_checker #(.DEPTH_W(DEPTH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .depth(depth),
    .mem_req(mem_req), .mem_valid(mem_valid), .busy(busy), .done(done)
);

// File: tb/oau_top_tb.sv
// Bench: sweeps all mode codes over A, register selection, depth and memory
// latency. Memory content is the function f(x) = 37*x + 11 mod 256.
module oau_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NREG = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [3:0]     mode = '0;
    logic [W-1:0]   addr_a = '0;
    logic [1:0]     reg_sel = '0;
    logic [1:0]     depth = '0;
    logic [NREG*W-1:0] regs_flat = '0;
    logic [W-1:0]   pc = '0;
    logic           mem_req;
    logic [W-1:0]   mem_addr;
    logic           mem_valid = 1'b0;
    logic [W-1:0]   mem_rdata = '0;
    logic           busy, done;
    logic [W-1:0]   operand;

    int checks = 0;
    int fails  = 0;
    int nreads = 0;
    int cycles = 0;
    int lat    = 1;
    int pcnt   = 0;
    logic [W-1:0] paddr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oau_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr_a(addr_a),
        .reg_sel(reg_sel), .depth(depth), .regs_flat(regs_flat), .pc(pc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .operand(operand)
    );

    function automatic logic [W-1:0] f(input logic [W-1:0] x);
        return x * 8'd37 + 8'd11;
    endfunction

    // Memory model with a latency of lat cycles; also counts requests.
    always @(posedge clk) begin
        mem_valid <= 1'b0;
        if (mem_req) begin
            nreads <= nreads + 1;
            if (lat == 1) begin
                mem_valid <= 1'b1;
                mem_rdata <= f(mem_addr);
            end else begin
                paddr <= mem_addr;
                pcnt  <= lat - 1;
            end
        end else if (pcnt == 1) begin
            mem_valid <= 1'b1;
            mem_rdata <= f(paddr);
            pcnt      <= 0;
        end else if (pcnt > 1) begin
            pcnt <= pcnt - 1;
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag(input logic [3:0] m);
        case (m)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4 R13";
            4'd4: return "R5 R13";
            4'd5: return "R6 R13";
            4'd6: return "R7 R13";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R12";
        endcase
    endfunction

    // Runs one operation; stray asks for an extra start while busy (R11).
    task automatic run_op(input logic [3:0] m, input logic [W-1:0] a,
                          input logic [1:0] rs, input logic [1:0] d, input bit stray);
        logic [W-1:0] rv, p, ev;
        int er, base, wait_n;
        logic [W-1:0] held;
        @(negedge clk);
        for (int i = 0; i < NREG; i++) regs_flat[i*W +: W] = a * 8'd5 + 8'(i * 29 + 3);
        pc = (a ^ 8'hC3) + 8'd7;
        rv = regs_flat[rs*W +: W];
        mode = m; addr_a = a; reg_sel = rs; depth = d; start = 1'b1;
        base = nreads;
        case (m)
            4'd1: begin ev = f(a); er = 1; end
            4'd2: begin
                p = a;
                er = (d == 0) ? 2 : d + 1;
                for (int k = 0; k < er; k++) p = f(p);
                ev = p;
            end
            4'd3: begin ev = rv; er = 0; end
            4'd4: begin ev = f(rv); er = 1; end
            4'd5: begin ev = f(a + rv); er = 1; end
            4'd6: begin ev = f(a + pc); er = 1; end
            4'd7: begin ev = f(f(a + rv)); er = 2; end
            4'd8: begin ev = f(f(a) + rv); er = 2; end
            default: begin ev = a; er = 0; end
        endcase
        @(negedge clk);
        start = 1'b0;
        // R13: scramble registers and PC after the start cycle.
        regs_flat = ~regs_flat;
        pc = pc + 8'd99;
        if (stray) begin
            check("R11 busy after start", int'(busy), 1);
            start = 1'b1; mode = 4'd1; addr_a = a + 8'd1;
        end
        wait_n = 0;
        while (!done && wait_n < 200) begin
            @(negedge clk);
            start = 1'b0;
            wait_n++;
        end
        start = 1'b0;
        check({tag(m), " operand"}, int'(operand), int'(ev));
        check({tag(m), " R10 read count"}, nreads - base, er);
        held = operand;
        @(negedge clk);
        @(negedge clk);
        check("R10 R11 idle and operand held", {busy, done, operand},
              {2'b00, held});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state.
        check("R11 reset busy", int'(busy), 0);
        check("R10 reset done", int'(done), 0);
        check("R10 reset req", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: every depth, including 0 treated as 1, at two latencies.
        for (int l = 1; l <= 3; l += 2) begin
            lat = l;
            for (int d = 0; d < 4; d++) run_op(4'd2, 8'(d * 50 + 9), 2'd0, 2'(d), 1'b0);
        end
        // Sweep every mode code over A values, selectors and latencies.
        for (int m = 0; m < 16; m++)
            for (int a = 0; a < 256; a += 17)
                for (int r = 0; r < 4; r++) begin
                    lat = 1 + ((a + r) % 3);
                    run_op(4'(m), 8'(a), 2'(r), 2'((a >> 4) + r), r == 1);
                end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule